// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block turns single host write requests into timed write cycles on an external asynchronous static RAM with a 16-bit data bus split into two byte lanes. A request carries an address, write data, one enable bit per byte lane and a framing-mode bit. The programmed counts are captured when the request is taken. The sequencer then steps through a fixed series of phases: address setup, strobe arming, the write pulse with data driven, data hold after the terminating edge, and write recovery. It drives the write enable, a chip-select pair of opposite polarity, the per-lane strobes, the address, the data and a tri-state enable for the data bus.

Two framings are offered. In write-enable framing, write enable is the strobe that ends the pulse, and the chip selects and lane strobes release after the hold interval. In chip-select framing, the chip selects and lane strobes end the pulse, and write enable releases after the hold interval. In both framings every strobe asserts in the same clock cycle. No chip select or lane strobe ever goes active before write enable, so the RAM never turns its own outputs on during a write. A request with no lane enabled is acknowledged without any strobe activity.

Top module: `sram_wr_seq`

## Requirements
- R1: After reset and whenever idle, reqReady is 1, memWeN is 1, memChipSelN is 1, memChipSel is 0, every bit of memByteSelN is 1 and memDoutEn is 0.
- R2: A request is taken on a clock edge where reqValid and reqReady are both 1. reqReady stays 0 from that edge until the cycle after done.
- R3: From the cycle after acceptance, memAddr carries the request address with all strobes inactive for exactly eff(cfgSetup) cycles, where eff(x) is x for x>0 and 1 for x=0.
- R4: memWeN, memChipSelN, memChipSel and the enabled lane strobes all go active in the same cycle, and no chip select goes active without write enable going active in that same cycle. memByteSelN[1] is the upper lane and follows reqBe[1]; memByteSelN[0] is the lower lane and follows reqBe[0]; a lane whose enable is 0 stays high. memChipSelN always equals the inverse of memChipSel.
- R5: memDoutEn rises one cycle after the strobes go active. From then on, memDout equals the request data, and all strobes stay active with the data driven for eff(cfgPulse) cycles.
- R6: With reqCsMode=0 (write-enable framing), memWeN releases first. The chip selects and enabled lane strobes stay active with the data driven for eff(cfgHold) cycles, then release together with memDoutEn.
- R7: With reqCsMode=1 (chip-select framing), the chip selects and lane strobes release first. memWeN stays low with the data driven for eff(cfgHold) cycles, then releases together with memDoutEn.
- R8: memDoutEn is never 1 while both memWeN and memChipSelN are 1.
- R9: After the hold phase, all strobes stay inactive for eff(cfgRecov) cycles. done is 1 in the last of these cycles, and reqReady is 1 in the following cycle.
- R10: A count of 0 for any of cfgSetup, cfgPulse, cfgHold or cfgRecov produces the same timing as a count of 1.
- R11: A request with reqBe=0 raises done in the cycle after acceptance. No strobe toggles and memAddr keeps its previous value.
- R12: memAddr holds the request address from the cycle after acceptance until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Sequencer idle and able to take a request |
| reqAddr | input | ADDR_W | Write address |
| reqData | input | DATA_W | Write data |
| reqBe | input | LANES | Lane enables, bit 1 upper, bit 0 lower |
| reqCsMode | input | 1 | 0 write-enable framing, 1 chip-select framing |
| cfgSetup | input | CNT_W | Address setup cycles |
| cfgPulse | input | CNT_W | Write pulse cycles with data driven |
| cfgHold | input | CNT_W | Data hold cycles after the terminating edge |
| cfgRecov | input | CNT_W | Write recovery cycles |
| done | output | 1 | One-cycle completion pulse |
| memAddr | output | ADDR_W | RAM address |
| memWeN | output | 1 | Write enable, active low |
| memChipSelN | output | 1 | First chip select, active low |
| memChipSel | output | 1 | Second chip select, active high |
| memByteSelN | output | LANES | Lane strobes, active low |
| memDout | output | DATA_W | Data to the bus |
| memDoutEn | output | 1 | Tri-state enable for memDout |

## Verification
The assertions check the invariants on every cycle. These are the standby levels while idle, the chip-select pair staying complementary, the chip selects never falling ahead of write enable, lane strobes only while selected, the data enable only while write enable or the chip select is active, and address stability while busy. The phase lengths can only be shown by the bench scenarios, because the programmed counts are invisible at the pins once a request has been taken. The same holds for which strobe group releases first in each framing, the data value on the bus, zero-count substitution and the silent completion of an empty request. The bench checks these against values it computes from each request.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ARM,
    ST_PULSE,
    ST_HOLD,
    ST_RECOV,
    ST_SKIP
  } wrState_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic load;     // capture request fields
    logic weOn;     // write enable active
    logic selOn;    // chip selects and enabled lanes active
    logic driveOn;  // drive write data onto the bus
  } wrStrobe_t;

endpackage

// File: rtl/sram_wr_ctrl.sv
module sram_wr_ctrl
  import sram_wr_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqBeAny,
  input  logic             reqCsMode,
  input  logic [CNT_W-1:0] cfgSetup,
  input  logic [CNT_W-1:0] cfgPulse,
  input  logic [CNT_W-1:0] cfgHold,
  input  logic [CNT_W-1:0] cfgRecov,
  output logic             reqReady,
  output logic             done,
  output wrStrobe_t        stb
);

  localparam logic [CNT_W-1:0] ONE  = 1;
  localparam logic [CNT_W-1:0] ZERO = '0;

  wrState_t         state, stateD;
  logic [CNT_W-1:0] cnt, cntD;
  logic [CNT_W-1:0] pulseM1, holdM1, recovM1;
  logic             csModeQ;

  // Effective count minus one; a programmed zero behaves as one
  function automatic logic [CNT_W-1:0] effM1(input logic [CNT_W-1:0] v);
    return (v == ZERO) ? ZERO : v - ONE;
  endfunction

  always_comb begin
    stateD = state;
    cntD   = cnt;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (reqBeAny) begin
            stateD = ST_SETUP;
            cntD   = effM1(cfgSetup);
          end else begin
            stateD = ST_SKIP;
          end
        end
      end
      ST_SETUP: begin
        if (cnt == ZERO) stateD = ST_ARM;
        else             cntD   = cnt - ONE;
      end
      ST_ARM: begin
        stateD = ST_PULSE;
        cntD   = pulseM1;
      end
      ST_PULSE: begin
        if (cnt == ZERO) begin
          stateD = ST_HOLD;
          cntD   = holdM1;
        end else begin
          cntD = cnt - ONE;
        end
      end
      ST_HOLD: begin
        if (cnt == ZERO) begin
          stateD = ST_RECOV;
          cntD   = recovM1;
        end else begin
          cntD = cnt - ONE;
        end
      end
      ST_RECOV: begin
        if (cnt == ZERO) stateD = ST_IDLE;
        else             cntD   = cnt - ONE;
      end
      ST_SKIP: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= ZERO;
      pulseM1 <= ZERO;
      holdM1  <= ZERO;
      recovM1 <= ZERO;
      csModeQ <= 1'b0;
    end else begin
      state <= stateD;
      cnt   <= cntD;
      if (state == ST_IDLE && reqValid) begin
        csModeQ <= reqCsMode;
        pulseM1 <= effM1(cfgPulse);
        holdM1  <= effM1(cfgHold);
        recovM1 <= effM1(cfgRecov);
      end
    end
  end

  // Strobe decode from the registered state
  always_comb begin
    stb.load    = (state == ST_IDLE) && reqValid && reqBeAny;
    stb.weOn    = (state == ST_ARM) || (state == ST_PULSE) ||
                  ((state == ST_HOLD) && csModeQ);
    stb.selOn   = (state == ST_ARM) || (state == ST_PULSE) ||
                  ((state == ST_HOLD) && !csModeQ);
    stb.driveOn = (state == ST_PULSE) || (state == ST_HOLD);
  end

  assign reqReady = (state == ST_IDLE);
  assign done     = ((state == ST_RECOV) && (cnt == ZERO)) || (state == ST_SKIP);

endmodule

// File: rtl/sram_wr_dp.sv
module sram_wr_dp
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [LANES-1:0]  reqBe,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWeN,
  output logic              memChipSelN,
  output logic              memChipSel,
  output logic [LANES-1:0]  memByteSelN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [LANES-1:0]  beQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      beQ   <= '0;
    end else if (stb.load) begin
      addrQ <= reqAddr;
      dataQ <= reqData;
      beQ   <= reqBe;
    end
  end

  assign memAddr     = addrQ;
  assign memDout     = dataQ;
  assign memDoutEn   = stb.driveOn;
  assign memWeN      = ~stb.weOn;
  assign memChipSelN = ~stb.selOn;
  assign memChipSel  = stb.selOn;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign memByteSelN[g] = ~(stb.selOn & beQ[g]);
  end

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [LANES-1:0]  reqBe,
  input  logic              reqCsMode,
  input  logic [CNT_W-1:0]  cfgSetup,
  input  logic [CNT_W-1:0]  cfgPulse,
  input  logic [CNT_W-1:0]  cfgHold,
  input  logic [CNT_W-1:0]  cfgRecov,
  output logic              done,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWeN,
  output logic              memChipSelN,
  output logic              memChipSel,
  output logic [LANES-1:0]  memByteSelN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn
);

  wrStrobe_t stb;

  sram_wr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqBeAny (|reqBe),
    .reqCsMode(reqCsMode),
    .cfgSetup (cfgSetup),
    .cfgPulse (cfgPulse),
    .cfgHold  (cfgHold),
    .cfgRecov (cfgRecov),
    .reqReady (reqReady),
    .done     (done),
    .stb      (stb)
  );

  sram_wr_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .reqAddr    (reqAddr),
    .reqData    (reqData),
    .reqBe      (reqBe),
    .memAddr    (memAddr),
    .memWeN     (memWeN),
    .memChipSelN(memChipSelN),
    .memChipSel (memChipSel),
    .memByteSelN(memByteSelN),
    .memDout    (memDout),
    .memDoutEn  (memDoutEn)
  );

endmodule

// File: rtl/sram_wr_seq_chk.sv
module sram_wr_seq_chk #(
  parameter int ADDR_W = 18,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              done,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memWeN,
  input logic              memChipSelN,
  input logic              memChipSel,
  input logic [LANES-1:0]  memByteSelN,
  input logic              memDoutEn
);

  assert_idle_standby_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memWeN && memChipSelN && !memChipSel && (&memByteSelN) && !memDoutEn));

  assert_sel_pair_R4: assert property (@(posedge clk) disable iff (!rstN)
    memChipSelN == !memChipSel);

  assert_sel_not_before_we_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memChipSelN) |-> $fell(memWeN));

  assert_lane_needs_sel_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!(&memByteSelN)) |-> (!memChipSelN && memChipSel));

  assert_drive_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    memDoutEn |-> (!memWeN || !memChipSelN));

  assert_drive_after_arm_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memDoutEn) |-> ($past(!memWeN) && $past(!memChipSelN)));

  assert_ready_after_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> reqReady);

  assert_addr_stable_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!reqReady && $past(!reqReady)) |-> $stable(memAddr));

endmodule

bind sram_wr_seq sram_wr_seq_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqReady   (reqReady),
  .done       (done),
  .memAddr    (memAddr),
  .memWeN     (memWeN),
  .memChipSelN(memChipSelN),
  .memChipSel (memChipSel),
  .memByteSelN(memByteSelN),
  .memDoutEn  (memDoutEn)
);

// File: tb/sram_wr_seq_tb.sv
module sram_wr_seq_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic        reqReady;
  logic [17:0] reqAddr;
  logic [15:0] reqData;
  logic [1:0]  reqBe;
  logic        reqCsMode;
  logic [3:0]  cfgSetup, cfgPulse, cfgHold, cfgRecov;
  logic        done;
  logic [17:0] memAddr;
  logic        memWeN, memChipSelN, memChipSel;
  logic [1:0]  memByteSelN;
  logic [15:0] memDout;
  logic        memDoutEn;

  always #4 clk = ~clk;

  sram_wr_seq u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqData(reqData), .reqBe(reqBe), .reqCsMode(reqCsMode),
    .cfgSetup(cfgSetup), .cfgPulse(cfgPulse), .cfgHold(cfgHold), .cfgRecov(cfgRecov),
    .done(done), .memAddr(memAddr), .memWeN(memWeN), .memChipSelN(memChipSelN),
    .memChipSel(memChipSel), .memByteSelN(memByteSelN), .memDout(memDout),
    .memDoutEn(memDoutEn)
  );

  typedef struct {
    logic [17:0] addr;
    logic [15:0] data;
    logic [1:0]  be;
    logic        mode;
    int          s, p, h, r;
    string       note;
  } expItem_t;

  expItem_t q[$];
  expItem_t e;
  int nChecks = 0;
  int nFails  = 0;
  int mst     = 0;
  int cnt     = 0;
  bit addrOk, dataOk, busyOk;
  logic [17:0] lastAddr = '0;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic int effc(input int x);
    return (x == 0) ? 1 : x;
  endfunction

  // Driver: waits for idle, records the expected cycle, presents the request
  task automatic issue(input logic [17:0] a, input logic [15:0] d, input logic [1:0] be,
                       input logic m, input int s, input int p, input int h, input int r,
                       input string note);
    expItem_t it;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    it.addr = a; it.data = d; it.be = be; it.mode = m;
    it.s = effc(s); it.p = effc(p); it.h = effc(h); it.r = effc(r); it.note = note;
    q.push_back(it);
    reqValid = 1'b1; reqAddr = a; reqData = d; reqBe = be; reqCsMode = m;
    cfgSetup = 4'(s); cfgPulse = 4'(p); cfgHold = 4'(h); cfgRecov = 4'(r);
    @(negedge clk);
    reqValid = 1'b0;
    reqAddr  = ~a;  // later changes must not reach the bus
    reqData  = ~d;
  endtask

  // Monitor: classifies the strobe lines each cycle and times the phases
  always @(negedge clk) begin
    bit idleLines, full, relWe, relSel;
    idleLines = memWeN && memChipSelN && !memChipSel && (memByteSelN == 2'b11);
    full   = !memWeN && !memChipSelN && memChipSel && (memByteSelN == ~e.be);
    relWe  = memWeN && !memChipSelN && memChipSel && (memByteSelN == ~e.be);
    relSel = !memWeN && memChipSelN && !memChipSel && (memByteSelN == 2'b11);
    if (rstN) begin
      if (mst >= 1 && mst <= 4) begin
        addrOk &= (memAddr == e.addr);
        busyOk &= !reqReady;
      end
      case (mst)
        0: if (!reqReady) begin
          check(q.size() != 0, "R2 busy without request", q.size(), 1);
          if (q.size() != 0) begin
            e = q.pop_front();
            if (e.be == 2'b00) begin
              // R11: empty request completes at once, nothing toggles
              check(done && idleLines && !memDoutEn, {"R11 silent done ", e.note},
                    {done, idleLines}, 2'b11);
              check(memAddr == lastAddr, {"R11 address kept ", e.note}, memAddr, lastAddr);
            end else begin
              addrOk = (memAddr == e.addr);
              busyOk = 1'b1;
              dataOk = 1'b1;
              check(idleLines && !memDoutEn, {"R3 setup lines idle ", e.note}, idleLines, 1);
              cnt = 1;
              mst = 1;
            end
          end
        end
        1: begin
          if (idleLines && !memDoutEn) cnt++;
          else if (full && !memDoutEn) begin
            check(cnt == e.s, {"R3 setup length ", e.note}, cnt, e.s);
            cnt = 0;
            mst = 2;
          end else begin
            check(1'b0, {"R4 strobe pattern at arm ", e.note},
                  {memWeN, memChipSelN, memChipSel, memByteSelN}, {3'b001, ~e.be});
            mst = 0;
          end
        end
        2: begin
          if (full && memDoutEn) begin
            cnt++;
            dataOk &= (memDout == e.data);
          end else if (memDoutEn) begin
            check(cnt == e.p, {"R5 pulse length ", e.note}, cnt, e.p);
            check(dataOk, {"R5 pulse data ", e.note}, memDout, e.data);
            if (e.mode) check(relSel, {"R7 chip selects release first ", e.note},
                              {memWeN, memChipSelN, memChipSel, memByteSelN}, 5'b01011);
            else        check(relWe, {"R6 write enable releases first ", e.note},
                              {memWeN, memChipSelN, memChipSel, memByteSelN}, {3'b101, ~e.be});
            dataOk = (memDout == e.data);
            cnt = 1;
            mst = 3;
          end else begin
            check(1'b0, {"R5 data enable dropped early ", e.note}, memDoutEn, 1);
            mst = 0;
          end
        end
        3: begin
          if (memDoutEn && (e.mode ? relSel : relWe)) begin
            cnt++;
            dataOk &= (memDout == e.data);
          end else if (idleLines && !memDoutEn) begin
            check(cnt == e.h, {e.mode ? "R7 hold length " : "R6 hold length ", e.note}, cnt, e.h);
            check(dataOk, {"R8 hold data ", e.note}, memDout, e.data);
            cnt = 1;
            mst = 4;
            if (done) begin
              check(cnt == e.r, {"R9 recovery length ", e.note}, cnt, e.r);
              check(addrOk, {"R12 address stable ", e.note}, memAddr, e.addr);
              check(busyOk, {"R2 ready low while busy ", e.note}, busyOk, 1);
              lastAddr = e.addr;
              mst = 5;
            end
          end else begin
            check(1'b0, {"R8 hold phase pattern ", e.note},
                  {memWeN, memChipSelN, memChipSel, memByteSelN, memDoutEn}, 0);
            mst = 0;
          end
        end
        4: begin
          if (!(idleLines && !memDoutEn)) begin
            check(1'b0, {"R9 strobe during recovery ", e.note}, idleLines, 1);
            mst = 0;
          end else if (done) begin
            cnt++;
            check(cnt == e.r, {"R9 recovery length ", e.note}, cnt, e.r);
            check(addrOk, {"R12 address stable ", e.note}, memAddr, e.addr);
            check(busyOk, {"R2 ready low while busy ", e.note}, busyOk, 1);
            lastAddr = e.addr;
            mst = 5;
          end else cnt++;
        end
        5: begin
          check(reqReady && !done, {"R9 ready after done ", e.note}, reqReady, 1);
          mst = 0;
        end
        default: mst = 0;
      endcase
    end
  end

  task automatic finish();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish();
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0; reqData = '0; reqBe = '0;
    reqCsMode = 1'b0; cfgSetup = '0; cfgPulse = '0; cfgHold = '0; cfgRecov = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && memWeN && memChipSelN && !memChipSel && memByteSelN == 2'b11 &&
          !memDoutEn && !done, "R1 reset levels", reqReady, 1);

    issue(18'h12345, 16'hA5C3, 2'b11, 1'b0, 2, 3, 2, 2, "we-framed both lanes");
    issue(18'h00F0F, 16'h1234, 2'b01, 1'b1, 1, 1, 1, 1, "cs-framed lower lane");
    issue(18'h2AAAA, 16'hBEEF, 2'b10, 1'b0, 0, 0, 0, 0, "R10 zero counts we-framed");
    issue(18'h3FFFF, 16'hDEAD, 2'b00, 1'b0, 3, 3, 3, 3, "R11 no lanes");
    issue(18'h15555, 16'h0F0F, 2'b10, 1'b1, 15, 15, 15, 15, "cs-framed max counts");
    issue(18'h00001, 16'hFFFF, 2'b01, 1'b0, 3, 2, 4, 3, "we-framed lower lane");
    issue(18'h20000, 16'h8001, 2'b11, 1'b1, 0, 2, 0, 5, "R10 zero counts cs-framed");
    issue(18'h0ABCD, 16'h0000, 2'b00, 1'b1, 1, 1, 1, 1, "R11 no lanes cs mode");

    while (q.size() != 0 || mst != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(reqReady && memWeN && memChipSelN && !memDoutEn, "R1 idle after run", reqReady, 1);
    finish();
  end

endmodule